// File: doc/BRIEF.md
# Almost-Full/Almost-Empty Offset Configuration Controller

This block is the configuration logic that sits in front of a pair of dual-clock FIFOs with 36-bit words, one carrying data from port A to port B and the other carrying data back. It owns the four threshold offsets used by the flag comparators: almost-full for the port A side, almost-empty for the port B side, almost-full for the port B side and almost-empty for the port A side. The FIFO memories and the comparators live elsewhere. This block only produces the four offset values, the two input-ready flags and a strobe that marks a port A write as a real data word.

Each FIFO has its own active-low reset. While a reset is held, a two-bit select input decides how the offsets of that FIFO start out. One code loads a fixed preset of eight. Another code clears the offsets and arms a programming sequence. In that sequence, the first four qualified port A writes after reset supply the offsets in a fixed order. Any remaining code loads a wider default preset. Once the offsets are settled, port A is handed over to ordinary FIFO writes. The completion event is carried into the port B clock domain through a two-flop synchronizer, and this raises the port B input-ready flag.

Top module: `fifo_offset_prog`

## Requirements
- R1: While a reset input is low with `fsel` = 2'b01, the two offsets that belong to that reset are loaded with the value 8 on every `clk_a` edge, and no programming writes are expected afterwards.
- R2: While any reset is low with `fsel` = 2'b00, the offsets of the reset pair are cleared to 0. After release, the first four accepted writes fill the offsets in this order: `af_a_off`, `ae_b_off`, `af_b_off`, `ae_a_off`.
- R3: A port A write is accepted on a rising `clk_a` edge only when all of these hold: `wr_en`=1, `cs_n`=0, `rw_sel`=1, `mbx_sel`=0 and `ir_a`=1. When any term is missing, the write changes no offset and raises no `fifo1_wr`.
- R4: Cycles without an accepted write leave the programming position and every offset unchanged, so the four programming writes may be separated by any number of idle cycles.
- R5: After the fourth programming write, and at any time in a preset mode, an accepted write raises `fifo1_wr` in that cycle and leaves all offsets unchanged. `fifo1_wr` is never high while programming writes are still pending.
- R6: Only bits [9:0] of `a_data` are stored by a programming write. Bits [35:10] have no effect on any offset.
- R7: `ir_a` is low one edge after a reset edge. It rises on the second `clk_a` edge after both resets are high.
- R8: `ir_b` is low until offset setup has completed, that is, on the `clk_a` edge after `ir_a` rises in preset modes or on the edge of the fourth programming write. It then rises after 2 (at most 3) `clk_b` edges, and it stays low whenever `ir_a` is low outside reset.
- R9: `rst1_n` loads only `af_a_off` and `ae_b_off`, and `rst2_n` loads only `af_b_off` and `ae_a_off`. Either reset restarts the mode, the programming position and both ready flags.
- R10: While a reset is low with `fsel` = 2'b10 or 2'b11, the offsets of that reset pair are loaded with 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst1_n | input | 1 | Active-low reset of the A-to-B FIFO, sampled on `clk_a` |
| rst2_n | input | 1 | Active-low reset of the B-to-A FIFO, sampled on `clk_a` |
| fsel | input | 2 | Offset setup select, sampled while a reset is low |
| wr_en | input | 1 | Port A enable |
| cs_n | input | 1 | Port A chip select, active low |
| rw_sel | input | 1 | Port A direction, 1 = write |
| mbx_sel | input | 1 | Port A mailbox select, must be 0 for offset or FIFO writes |
| a_data | input | 36 | Port A data bus |
| af_a_off | output | 10 | Almost-full offset, port A side (first programmed) |
| ae_b_off | output | 10 | Almost-empty offset, port B side (second programmed) |
| af_b_off | output | 10 | Almost-full offset, port B side (third programmed) |
| ae_a_off | output | 10 | Almost-empty offset, port A side (fourth programmed) |
| ir_a | output | 1 | Port A input-ready flag |
| ir_b | output | 1 | Port B input-ready flag, synchronized to `clk_b` |
| fifo1_wr | output | 1 | Accepted port A write that is a FIFO data word |

## Verification
The assertions check on every cycle that offsets move only on a programming write or a reset, that a data-word write never disturbs them, that the preset value lands while a reset is held, that `ir_a` drops under reset, and that `ir_b` never runs ahead of `ir_a`. The bench scenarios are needed to show the fixed write order across idle gaps and rejected cycles, the masking of the upper data bits, the choice of the default preset, and the separation between the two resets. They are also needed to measure the `clk_b` latency of `ir_b` across drifting clock phases.

// File: rtl/fop_pkg.sv
`timescale 1ns/100ps
package fop_pkg;

    typedef enum logic [1:0] {
        MODE_PROG   = 2'd0,
        MODE_PRESET = 2'd1,
        MODE_DFLT   = 2'd2
    } mode_e;

    localparam int NUM_OFF = 4;

    // Programming order is behaviour: index equals write position.
    localparam int OFF_AF_A = 0;
    localparam int OFF_AE_B = 1;
    localparam int OFF_AF_B = 2;
    localparam int OFF_AE_A = 3;

    function automatic mode_e fsel_mode(input logic [1:0] fs);
        case (fs)
            2'b00:   return MODE_PROG;
            2'b01:   return MODE_PRESET;
            default: return MODE_DFLT;
        endcase
    endfunction

endpackage

// File: rtl/fop_ready_timer.sv
`timescale 1ns/100ps
module fop_ready_timer #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rdy;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!rst_n) begin
            t_d.cnt = '0;
            t_d.rdy = 1'b0;
        end else if (!t_q.rdy) begin
            t_d.cnt = t_q.cnt + 1'b1;
            if (t_q.cnt == LAST) begin
                t_d.rdy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    assign ready = t_q.rdy;

endmodule

// File: rtl/fop_sync.sv
`timescale 1ns/100ps
module fop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/fop_seq.sv
`timescale 1ns/100ps
module fop_seq
    import fop_pkg::*;
#(
    parameter int OFF_W      = 10,
    parameter int PRESET_OFF = 8,
    parameter int DFLT_OFF   = 64
) (
    input  logic                            clk,
    input  logic                            rst1_n,
    input  logic                            rst2_n,
    input  logic [1:0]                      fsel,
    input  logic                            ready,
    input  logic                            wr_en,
    input  logic                            cs_n,
    input  logic                            rw_sel,
    input  logic                            mbx_sel,
    input  logic [OFF_W-1:0]                wr_data,
    output logic [NUM_OFF-1:0][OFF_W-1:0]   off,
    output logic                            off_wr,
    output logic                            data_wr,
    output logic                            done
);
    localparam int PTR_W = $clog2(NUM_OFF + 1);
    localparam int IDX_W = $clog2(NUM_OFF);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_OFF);

    typedef struct packed {
        mode_e                          mode;
        logic [PTR_W-1:0]               ptr;
        logic                           done;
        logic [NUM_OFF-1:0][OFF_W-1:0]  off;
    } seq_t;

    seq_t s_d, s_q;
    logic acc;
    logic prog_open;
    logic [OFF_W-1:0] load_val;

    // Value placed in an offset register while its reset is held.
    always_comb begin
        case (fsel_mode(fsel))
            MODE_PROG:   load_val = '0;
            MODE_PRESET: load_val = OFF_W'(PRESET_OFF);
            default:     load_val = OFF_W'(DFLT_OFF);
        endcase
    end

    always_comb begin
        acc       = ready & wr_en & ~cs_n & rw_sel & ~mbx_sel;
        prog_open = (s_q.mode == MODE_PROG) && (s_q.ptr != PTR_END);
        off_wr    = acc & prog_open;
        data_wr   = acc & ~prog_open;

        s_d = s_q;
        if (!rst1_n || !rst2_n) begin
            s_d.mode = fsel_mode(fsel);
            s_d.ptr  = '0;
            s_d.done = 1'b0;
            if (!rst1_n) begin
                s_d.off[OFF_AF_A] = load_val;
                s_d.off[OFF_AE_B] = load_val;
            end
            if (!rst2_n) begin
                s_d.off[OFF_AF_B] = load_val;
                s_d.off[OFF_AE_A] = load_val;
            end
        end else begin
            if (off_wr) begin
                s_d.off[s_q.ptr[IDX_W-1:0]] = wr_data;
                s_d.ptr = s_q.ptr + 1'b1;
            end
            s_d.done = ready && ((s_q.mode != MODE_PROG) || (s_d.ptr == PTR_END));
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign off  = s_q.off;
    assign done = s_q.done;

endmodule

// File: rtl/fifo_offset_prog.sv
`timescale 1ns/100ps
module fifo_offset_prog
    import fop_pkg::*;
#(
    parameter int DATA_W      = 36,
    parameter int OFF_W       = 10,
    parameter int PRESET_OFF  = 8,
    parameter int DFLT_OFF    = 64,
    parameter int IRA_DLY     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst1_n,
    input  logic              rst2_n,
    input  logic [1:0]        fsel,
    input  logic              wr_en,
    input  logic              cs_n,
    input  logic              rw_sel,
    input  logic              mbx_sel,
    input  logic [DATA_W-1:0] a_data,
    output logic [OFF_W-1:0]  af_a_off,
    output logic [OFF_W-1:0]  ae_b_off,
    output logic [OFF_W-1:0]  af_b_off,
    output logic [OFF_W-1:0]  ae_a_off,
    output logic              ir_a,
    output logic              ir_b,
    output logic              fifo1_wr
);
    logic rst_all_n;
    logic off_wr;
    logic setup_done;
    logic unused_hi;
    logic [NUM_OFF-1:0][OFF_W-1:0] off;

    assign rst_all_n = rst1_n & rst2_n;
    // Upper data bits carry no offset information.
    assign unused_hi = ^a_data[DATA_W-1:OFF_W];

    fop_ready_timer #(
        .DLY (IRA_DLY)
    ) u_timer (
        .clk   (clk_a),
        .rst_n (rst_all_n),
        .ready (ir_a)
    );

    fop_seq #(
        .OFF_W      (OFF_W),
        .PRESET_OFF (PRESET_OFF),
        .DFLT_OFF   (DFLT_OFF)
    ) u_seq (
        .clk     (clk_a),
        .rst1_n  (rst1_n),
        .rst2_n  (rst2_n),
        .fsel    (fsel),
        .ready   (ir_a),
        .wr_en   (wr_en),
        .cs_n    (cs_n),
        .rw_sel  (rw_sel),
        .mbx_sel (mbx_sel),
        .wr_data (a_data[OFF_W-1:0]),
        .off     (off),
        .off_wr  (off_wr),
        .data_wr (fifo1_wr),
        .done    (setup_done)
    );

    fop_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync_b (
        .clk    (clk_b),
        .arst_n (rst_all_n),
        .d      (setup_done),
        .q      (ir_b)
    );

    assign af_a_off = off[OFF_AF_A];
    assign ae_b_off = off[OFF_AE_B];
    assign af_b_off = off[OFF_AF_B];
    assign ae_a_off = off[OFF_AE_A];

endmodule

// File: rtl/fop_chk.sv
`timescale 1ns/100ps
module fop_chk #(
    parameter int OFF_W      = 10,
    parameter int PRESET_OFF = 8
) (
    input logic             clk_a,
    input logic             rst1_n,
    input logic             rst2_n,
    input logic [1:0]       fsel,
    input logic             ir_a,
    input logic             ir_b,
    input logic             fifo1_wr,
    input logic             off_wr,
    input logic [OFF_W-1:0] af_a_off,
    input logic [OFF_W-1:0] ae_b_off,
    input logic [OFF_W-1:0] af_b_off,
    input logic [OFF_W-1:0] ae_a_off
);
    logic rst_all_n;
    logic [4*OFF_W-1:0] all_off;
    localparam logic [OFF_W-1:0] PV = OFF_W'(PRESET_OFF);

    assign rst_all_n = rst1_n & rst2_n;
    assign all_off   = {af_a_off, ae_b_off, af_b_off, ae_a_off};

    assert_preset_pair1_R1: assert property (@(posedge clk_a)
        (!rst1_n && fsel == 2'b01) |=> (af_a_off == PV && ae_b_off == PV));

    assert_preset_pair2_R1: assert property (@(posedge clk_a)
        (!rst2_n && fsel == 2'b01) |=> (af_b_off == PV && ae_a_off == PV));

    assert_offsets_hold_R4: assert property (@(posedge clk_a) disable iff (!rst_all_n)
        !off_wr |=> $stable(all_off));

    assert_dataword_keeps_offsets_R5: assert property (@(posedge clk_a) disable iff (!rst_all_n)
        fifo1_wr |=> $stable(all_off));

    assert_accept_needs_ready_R3: assert property (@(posedge clk_a) disable iff (!rst_all_n)
        (fifo1_wr || off_wr) |-> ir_a);

    assert_ira_low_in_reset_R7: assert property (@(posedge clk_a)
        !rst_all_n |=> !ir_a);

    assert_irb_after_ira_R8: assert property (@(posedge clk_a) disable iff (!rst_all_n)
        ir_b |-> ir_a);

    assert_irb_low_in_reset_R9: assert property (@(posedge clk_a)
        !rst_all_n |-> !ir_b);

endmodule

bind fifo_offset_prog fop_chk #(
    .OFF_W      (OFF_W),
    .PRESET_OFF (PRESET_OFF)
) u_chk (
    .clk_a    (clk_a),
    .rst1_n   (rst1_n),
    .rst2_n   (rst2_n),
    .fsel     (fsel),
    .ir_a     (ir_a),
    .ir_b     (ir_b),
    .fifo1_wr (fifo1_wr),
    .off_wr   (off_wr),
    .af_a_off (af_a_off),
    .ae_b_off (ae_b_off),
    .af_b_off (af_b_off),
    .ae_a_off (ae_a_off)
);

// File: tb/sim_fifo_offset_prog.sv
`timescale 1ns/100ps
module sim_fifo_offset_prog;
    localparam int IRA_DLY = 2;

    logic        clk_a = 1'b0;
    logic        clk_b = 1'b0;
    logic        rst1_n = 1'b0;
    logic        rst2_n = 1'b0;
    logic [1:0]  fsel = 2'b01;
    logic        wr_en = 1'b0;
    logic        cs_n = 1'b1;
    logic        rw_sel = 1'b0;
    logic        mbx_sel = 1'b0;
    logic [35:0] a_data = '0;
    logic [9:0]  af_a_off, ae_b_off, af_b_off, ae_a_off;
    logic        ir_a, ir_b, fifo1_wr;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 0;

    // Behavioural reference state
    int m_mode, m_idx, m_cnt;
    int m_off [4];
    bit m_ira, m_done, m_done_prev;
    event ev_done;

    fifo_offset_prog u0 (
        .clk_a(clk_a), .clk_b(clk_b), .rst1_n(rst1_n), .rst2_n(rst2_n),
        .fsel(fsel), .wr_en(wr_en), .cs_n(cs_n), .rw_sel(rw_sel),
        .mbx_sel(mbx_sel), .a_data(a_data),
        .af_a_off(af_a_off), .ae_b_off(ae_b_off), .af_b_off(af_b_off),
        .ae_a_off(ae_a_off), .ir_a(ir_a), .ir_b(ir_b), .fifo1_wr(fifo1_wr)
    );

    always #10 clk_a = ~clk_a;

    initial begin
        real ph;
        ph = 0.5 + real'($urandom % 20);
        #(ph);
        forever #13 clk_b = ~clk_b;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int preset_of(input logic [1:0] fs);
        if (fs == 2'b00) return 0;
        if (fs == 2'b01) return 8;
        return 64;
    endfunction

    // Reference model, advanced on each clk_a edge
    always @(posedge clk_a) begin
        bit ira_old;
        bit acc;
        ira_old = m_ira;
        if (!rst1_n || !rst2_n) begin
            m_mode = int'(fsel);
            m_idx = 0; m_cnt = 0; m_ira = 0; m_done = 0;
            if (!rst1_n) begin m_off[0] = preset_of(fsel); m_off[1] = preset_of(fsel); end
            if (!rst2_n) begin m_off[2] = preset_of(fsel); m_off[3] = preset_of(fsel); end
        end else begin
            acc = ira_old && wr_en && !cs_n && rw_sel && !mbx_sel;
            if (acc && m_mode == 0 && m_idx < 4) begin
                m_off[m_idx] = int'(a_data[9:0]);
                m_idx++;
            end
            if (!m_ira) begin
                m_cnt++;
                if (m_cnt == IRA_DLY) m_ira = 1;
            end
            m_done = ira_old && (m_mode != 0 || m_idx == 4);
        end
        if (m_done && !m_done_prev) -> ev_done;
        m_done_prev = m_done;
        started = 1;
    end

    // Per-cycle comparison, a quarter period before the next rising edge
    always @(negedge clk_a) begin
        bit exp_fw;
        #5;
        if (started) begin
            exp_fw = m_ira && wr_en && !cs_n && rw_sel && !mbx_sel
                     && !(m_mode == 0 && m_idx < 4);
            chk(int'(af_a_off) == m_off[0], "R2", "af_a_off", af_a_off, m_off[0]);
            chk(int'(ae_b_off) == m_off[1], "R2", "ae_b_off", ae_b_off, m_off[1]);
            chk(int'(af_b_off) == m_off[2], "R2", "af_b_off", af_b_off, m_off[2]);
            chk(int'(ae_a_off) == m_off[3], "R2", "ae_a_off", ae_a_off, m_off[3]);
            chk(ir_a === m_ira, "R7", "ir_a", ir_a, m_ira);
            chk(fifo1_wr === exp_fw, "R5", "fifo1_wr", fifo1_wr, exp_fw);
            if (!m_done) chk(ir_b === 1'b0, "R8", "ir_b before setup done", ir_b, 0);
        end
    end

    // R8: count clk_b edges from setup completion to ir_b high
    initial begin
        forever begin
            int n;
            @(ev_done);
            chk(ir_b === 1'b0, "R8", "ir_b at completion edge", ir_b, 0);
            n = 0;
            while (n < 6) begin
                @(posedge clk_b);
                #1;
                n++;
                if (ir_b === 1'b1) break;
            end
            chk(n == 2 || n == 3, "R8", "clk_b edges to ir_b", n, 2);
        end
    end

    task automatic bus(input logic w, input logic c, input logic r,
                       input logic m, input logic [35:0] d);
        @(negedge clk_a);
        wr_en = w; cs_n = c; rw_sel = r; mbx_sel = m; a_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus(1'b0, 1'b1, 1'b0, 1'b0, 36'h0);
    endtask

    task automatic do_reset(input bit r1, input bit r2, input logic [1:0] fs);
        @(negedge clk_a);
        rst1_n = !r1; rst2_n = !r2; fsel = fs;
        wr_en = 1'b0; cs_n = 1'b1; rw_sel = 1'b0; mbx_sel = 1'b0;
        repeat (3) @(negedge clk_a);
        rst1_n = 1'b1; rst2_n = 1'b1;
    endtask

    task automatic put(input logic [35:0] d);
        bus(1'b1, 1'b0, 1'b1, 1'b0, d);
    endtask

    initial begin
        #200000;
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Reset state with the preset of eight, R1
        do_reset(1, 1, 2'b01);
        #5;
        chk(ir_a === 1'b0, "R7", "ir_a right after release", ir_a, 0);
        idle(10);
        #5;
        chk(af_a_off == 10'd8 && ae_b_off == 10'd8, "R1", "pair 1 preset", af_a_off, 8);
        chk(af_b_off == 10'd8 && ae_a_off == 10'd8, "R1", "pair 2 preset", af_b_off, 8);
        chk(ir_a === 1'b1 && ir_b === 1'b1, "R8", "both ready after preset", {ir_a, ir_b}, 3);
        put(36'h0_0000_0123);
        #5;
        chk(fifo1_wr === 1'b1, "R5", "data word in preset mode", fifo1_wr, 1);
        idle(2);

        // Programming mode, R2 R3 R4 R6
        do_reset(1, 1, 2'b00);
        put(36'h0_0000_0155);            // ir_a still low: must be ignored
        idle(2);
        #5;
        chk(af_a_off == 10'd0, "R7", "write before ir_a ignored", af_a_off, 0);
        put(36'hF_FFFF_F0A5);            // first offset, upper bits set
        bus(1'b1, 1'b1, 1'b1, 1'b0, 36'h111);   // chip select high
        bus(1'b1, 1'b0, 1'b0, 1'b0, 36'h122);   // read direction
        bus(1'b1, 1'b0, 1'b1, 1'b1, 36'h133);   // mailbox selected
        bus(1'b0, 1'b0, 1'b1, 1'b0, 36'h144);   // enable low
        idle(3);
        #5;
        chk(ae_b_off == 10'd0, "R3", "unqualified writes ignored", ae_b_off, 0);
        chk(fifo1_wr === 1'b0, "R4", "no data write during gap", fifo1_wr, 0);
        put(36'h0_0000_03FF);
        put(36'h8_0000_0011);
        idle(4);
        #5;
        chk(af_b_off == 10'h011, "R4", "third offset after gap", af_b_off, 10'h011);
        chk(ir_b === 1'b0, "R8", "ir_b low before fourth write", ir_b, 0);
        put(36'h0_0000_0200);
        put(36'h0_0000_0777);
        #5;
        chk(fifo1_wr === 1'b1, "R5", "fifth write is data", fifo1_wr, 1);
        idle(8);
        #5;
        chk(af_a_off == 10'h0A5, "R6", "upper bits masked", af_a_off, 10'h0A5);
        chk(ae_b_off == 10'h3FF, "R2", "second offset", ae_b_off, 10'h3FF);
        chk(ae_a_off == 10'h200, "R2", "fourth offset", ae_a_off, 10'h200);
        chk(ir_b === 1'b1, "R8", "ir_b after programming", ir_b, 1);

        // Second reset alone, R9
        do_reset(0, 1, 2'b01);
        idle(8);
        #5;
        chk(af_a_off == 10'h0A5 && ae_b_off == 10'h3FF, "R9", "pair 1 kept",
            af_a_off, 10'h0A5);
        chk(af_b_off == 10'd8 && ae_a_off == 10'd8, "R9", "pair 2 preset", af_b_off, 8);

        // Default preset codes, R10
        do_reset(1, 1, 2'b10);
        idle(8);
        #5;
        chk(af_a_off == 10'd64 && ae_a_off == 10'd64, "R10", "code 10 default", af_a_off, 64);
        do_reset(1, 1, 2'b11);
        idle(8);
        #5;
        chk(ae_b_off == 10'd64 && af_b_off == 10'd64, "R10", "code 11 default", ae_b_off, 64);
        put(36'h0_0000_0001);
        #5;
        chk(fifo1_wr === 1'b1, "R5", "data word in default mode", fifo1_wr, 1);
        idle(8);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule